// File: doc/BRIEF.md
# Byte-wide asynchronous SRAM cycle controller

This block sits between a clocked host and a 2048 x 8 asynchronous static memory. The host issues a request with an address and a direction. The controller then drives the memory's active-low chip-enable, output-enable and write-enable strobes, the address bus, and a data bus that has a separate drive-enable. It runs the access for a fixed number of clock cycles in each phase. It finishes with a one-cycle acknowledge, and a read returns the captured byte.

The length of every phase is computed during elaboration from two parameters: the clock period in nanoseconds and the memory speed grade (100, 120, 150 or 200 ns). Each length is the ceiling of the relevant time divided by the clock period, and never less than one cycle. A write first holds write-enable low with the data driver off, which waits out the memory's 35 ns output turn-off. It then drives the data. The write ends on the rising edge of write-enable, while chip-enable stays low for a short tail.

A supervisor input reports whether the memory is usable. While it is low, no request is taken. If it falls during an access, the strobes are released at once and no acknowledge is given. The held request then runs again from the start once the supervisor input returns high.

Top module: `sramc_ctrl`

## Requirements
- R1: While reset is applied, and until the first request, chip-enable, output-enable and write-enable are all 1 (inactive), data drive-enable is 0 and ack is 0.
- R2: A read holds chip-enable and output-enable at 0 and write-enable at 1 for exactly N_RD = ceil(max(grade, output-enable access) / clock period) cycles. ack is then 1 for a single cycle, and rdata holds the byte the memory presented in the last cycle of that window. The first ack comes N_RD+1 cycles after the edge that accepts the request.
- R3: Output-enable stays at 1 whenever write-enable is 0, and chip-enable is 0 whenever write-enable is 0.
- R4: A write holds write-enable at 0 for N_ODW + N_WD cycles. N_ODW = ceil(35 ns / clock period). N_WD = max(1, ceil(data setup / period), ceil(pulse width / period) - N_ODW). Data drive-enable stays 0 for the first N_ODW of those cycles.
- R5: A write ends with write-enable rising while chip-enable stays 0 and the data stays driven for N_END = max(1, ceil(grade / period) - N_ODW - N_WD) more cycles. The write's ack then follows after N_ODW+N_WD+N_END+1 cycles.
- R6: mem_addr does not change while chip-enable stays at 0.
- R7: While mem_ready is 0, a pending request is not started. It starts on the first edge after mem_ready returns to 1.
- R8: If mem_ready is 0 at an edge during an access, that edge drives all strobes to 1 and drive-enable to 0, and no ack is given. A request still held is retried in full.
- R9: A request is never accepted on the edge that ends its ack cycle. A request held through that edge leaves chip-enable at 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 11 | Host byte address |
| wdata | input | 8 | Host write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with ack of a read |
| mem_ready | input | 1 | Supervisor: memory usable |
| mem_addr | output | 11 | Memory address bus |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_o |
| mem_dq_i | input | 8 | Data returned by the memory |

## Verification
A wrong phase counter shows up within one access as a strobe window that is one or more cycles too long or too short. It also shifts the ack cycle, and the bench measures both against the lengths computed from the requirements. A state register left in a write phase after an abort or an ack would show on the next cycle as a strobe still low, or as the data drive enabled with chip-enable high. A wrong capture edge or a bad address register returns a wrong byte on the next read of that location, which is compared with a model kept in the bench.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WTURN = 3'd2,
    ST_WDATA = 3'd3,
    ST_WEND  = 3'd4
  } sramc_state_e;

  localparam int TURNOFF_NS = 35;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return imax(1, (ns + clk_ns - 1) / clk_ns);
  endfunction

  function automatic int grade_oe_ns(input int g);
    case (g)
      120:     return 60;
      150:     return 70;
      200:     return 100;
      default: return 50;
    endcase
  endfunction

  function automatic int grade_wp_ns(input int g);
    case (g)
      120:     return 90;
      150:     return 100;
      200:     return 150;
      default: return 75;
    endcase
  endfunction

  function automatic int grade_ds_ns(input int g);
    case (g)
      120:     return 50;
      150:     return 60;
      200:     return 50;
      default: return 40;
    endcase
  endfunction

endpackage

// File: rtl/sramc_rst_sync.sv
module sramc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int N_RD  = 10,
  parameter int N_ODW = 4,
  parameter int N_WD  = 4,
  parameter int N_END = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic             mem_ready,
  input  logic             timer_done,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             ack,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);
  sramc_state_e st_q, st_d;
  logic ack_q, ack_d;
  logic ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d;

  always_comb begin
    st_d    = st_q;
    accept  = 1'b0;
    capture = 1'b0;
    ack_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req && mem_ready && !ack_q) begin
          accept = 1'b1;
          st_d   = we ? ST_WTURN : ST_READ;
        end
      end
      ST_READ: begin
        if (!mem_ready) st_d = ST_IDLE;
        else if (timer_done) begin
          st_d    = ST_IDLE;
          capture = 1'b1;
          ack_d   = 1'b1;
        end
      end
      ST_WTURN: begin
        if (!mem_ready)      st_d = ST_IDLE;
        else if (timer_done) st_d = ST_WDATA;
      end
      ST_WDATA: begin
        if (!mem_ready)      st_d = ST_IDLE;
        else if (timer_done) st_d = ST_WEND;
      end
      ST_WEND: begin
        if (!mem_ready) st_d = ST_IDLE;
        else if (timer_done) begin
          st_d  = ST_IDLE;
          ack_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load = (st_d != st_q) && (st_d != ST_IDLE);
    case (st_d)
      ST_READ:  load_val = CNT_W'(N_RD);
      ST_WTURN: load_val = CNT_W'(N_ODW);
      ST_WDATA: load_val = CNT_W'(N_WD);
      ST_WEND:  load_val = CNT_W'(N_END);
      default:  load_val = '0;
    endcase
  end

  // strobes decoded from the next state and registered
  always_comb begin
    ce_n_d  = (st_d == ST_IDLE);
    oe_n_d  = (st_d != ST_READ);
    we_n_d  = !((st_d == ST_WTURN) || (st_d == ST_WDATA));
    dq_oe_d = (st_d == ST_WDATA) || (st_d == ST_WEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ack_q   <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ack_q   <= ack_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  assign ack   = ack_q;
  assign ce_n  = ce_n_q;
  assign oe_n  = oe_n_q;
  assign we_n  = we_n_q;
  assign dq_oe = dq_oe_q;
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      addr_q <= addr;
      wd_q   <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (capture) rd_q <= mem_dq_i;
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wd_q;
  assign rdata    = rd_q;
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int GRADE_NS = 100,
  parameter int AW       = 11,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int N_RD  = ns_to_cyc(imax(GRADE_NS, grade_oe_ns(GRADE_NS)), CLK_NS);
  localparam int N_ODW = ns_to_cyc(TURNOFF_NS, CLK_NS);
  localparam int N_WD  = imax(1, imax(ns_to_cyc(grade_ds_ns(GRADE_NS), CLK_NS),
                                      ns_to_cyc(grade_wp_ns(GRADE_NS), CLK_NS) - N_ODW));
  localparam int N_END = imax(1, ns_to_cyc(GRADE_NS, CLK_NS) - N_ODW - N_WD);
  localparam int N_MAX = imax(imax(N_RD, N_ODW), imax(N_WD, N_END));
  localparam int CNT_W = $clog2(N_MAX + 1);

  logic             rst_int_n;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_done;
  logic             accept;
  logic             capture;

  sramc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  sramc_fsm #(
    .CNT_W (CNT_W),
    .N_RD  (N_RD),
    .N_ODW (N_ODW),
    .N_WD  (N_WD),
    .N_END (N_END)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req        (req),
    .we         (we),
    .mem_ready  (mem_ready),
    .timer_done (t_done),
    .load       (t_load),
    .load_val   (t_val),
    .accept     (accept),
    .capture    (capture),
    .ack        (ack),
    .ce_n       (mem_ce_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe)
  );

  sramc_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept   (accept),
    .capture  (capture),
    .addr     (addr),
    .wdata    (wdata),
    .mem_dq_i (mem_dq_i),
    .mem_addr (mem_addr),
    .mem_dq_o (mem_dq_o),
    .rdata    (rdata)
  );
endmodule

// File: rtl/sramc_ctrl_chk.sv
module sramc_ctrl_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_ready,
  input logic          ack,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);
  // R2: ack lasts one cycle
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R3: no output-enable during write-enable
  p_write_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  // R4: drive only after write-enable has been low for a cycle
  p_turnoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && !mem_we_n) |-> !$past(mem_we_n));

  // R5: a normal write ends on write-enable with chip-enable still low
  p_we_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && $past(mem_ready)) |-> !mem_ce_n);

  // R6: address held under chip-enable
  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> (mem_addr == $past(mem_addr)));

  // R7: nothing starts while not ready
  p_ready_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce_n && !mem_ready) |=> mem_ce_n);

  // R8: abort releases everything
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_ready) |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ack));

  // R9: no start on the edge closing an ack cycle
  p_no_start_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> mem_ce_n);
endmodule

bind sramc_ctrl sramc_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_ready (mem_ready),
  .ack       (ack),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sramc_ctrl_tb_top.sv
module sramc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GRADE      = 100;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD     = mx(1, cdiv(GRADE, CLK_PERIOD));
  localparam int E_ODW    = mx(1, cdiv(35, CLK_PERIOD));
  localparam int E_WD     = mx(1, mx(cdiv(40, CLK_PERIOD), cdiv(75, CLK_PERIOD) - E_ODW));
  localparam int E_END    = mx(1, cdiv(GRADE, CLK_PERIOD) - E_ODW - E_WD);
  localparam int E_LAT_RD = E_RD + 1;
  localparam int E_LAT_WR = E_ODW + E_WD + E_END + 1;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        we;
  logic [10:0] addr;
  logic [7:0]  wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic        mem_ready;
  logic [10:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_i;

  logic [7:0] model   [2048];
  logic [7:0] ref_mem [2048];

  int n_checks = 0;
  int n_errors = 0;

  sramc_ctrl #(.CLK_NS(CLK_PERIOD), .GRADE_NS(GRADE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model[mem_addr] : 8'h00;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // bus monitor and memory model
  logic       pce, pwe, poe, pdq_oe, pready;
  logic [7:0] pdq;
  logic [10:0] paddr;
  int we_low_n, turn_n, end_n, oe_low_n;
  int viol3, viol5, viol6;
  bit in_wend;

  always @(negedge clk) begin
    if (!rst_n) begin
      we_low_n = 0; turn_n = 0; end_n = 0; oe_low_n = 0; in_wend = 0;
      viol3 = 0; viol5 = 0; viol6 = 0;
    end else begin
      if (!mem_we_n && (!mem_oe_n || mem_ce_n)) viol3++;
      if (!pce && !mem_ce_n && (mem_addr != paddr)) viol6++;
      if (!pce && !pwe && !(!mem_ce_n && !mem_we_n))
        model[paddr] = pdq_oe ? pdq : 8'hEE;
      if (!mem_we_n) we_low_n++;
      if (!mem_we_n && !mem_dq_oe) turn_n++;
      if (!pwe && mem_we_n) begin
        if (!mem_ce_n) begin
          chk(we_low_n == E_ODW + E_WD, "R4 we low", we_low_n, E_ODW + E_WD);
          chk(turn_n == E_ODW, "R4 turn-off", turn_n, E_ODW);
          in_wend = 1; end_n = 0;
        end
        we_low_n = 0; turn_n = 0;
      end
      if (in_wend) begin
        if (!mem_ce_n) begin
          end_n++;
          if (!mem_dq_oe) viol5++;
        end else begin
          if (pready) chk(end_n == E_END, "R5 tail", end_n, E_END);
          in_wend = 0;
        end
      end
      if (!mem_oe_n) oe_low_n++;
      else if (!poe) begin
        if (pready) chk(oe_low_n == E_RD, "R2 read window", oe_low_n, E_RD);
        oe_low_n = 0;
      end
    end
    pce = mem_ce_n; pwe = mem_we_n; poe = mem_oe_n;
    pdq_oe = mem_dq_oe; pdq = mem_dq_o; paddr = mem_addr; pready = mem_ready;
  end

  task automatic wait_ack(output int lat);
    bit got;
    got = 0; lat = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      lat++;
      if (ack) got = 1;
    end
    if (!got) lat = -1;
  endtask

  task automatic finish_op(input bit w, input logic [10:0] a, input logic [7:0] d, input int lat);
    if (w) begin
      chk(lat == E_LAT_WR, "R5 write ack", lat, E_LAT_WR);
      ref_mem[a] = d;
    end else begin
      chk(lat == E_LAT_RD, "R2 read ack", lat, E_LAT_RD);
      chk(rdata == ref_mem[a], "R2 read data", rdata, ref_mem[a]);
    end
  endtask

  task automatic xfer(input bit w, input logic [10:0] a, input logic [7:0] d, input bit linger);
    int lat;
    req = 0;
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    wait_ack(lat);
    finish_op(w, a, d, lat);
    if (linger) begin
      @(negedge clk);
      chk(mem_ce_n == 1'b1, "R9 held req", mem_ce_n, 1);
    end
    req = 0;
  endtask

  task automatic xfer_abort(input bit w, input logic [10:0] a, input logic [7:0] d, input int k);
    int lat;
    req = 0;
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    repeat (k) @(negedge clk);
    mem_ready = 0;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ack, "R8 release",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}, 5'b11100);
    @(negedge clk);
    chk(mem_ce_n && !ack, "R7 held off after abort", mem_ce_n, 1);
    mem_ready = 1;
    wait_ack(lat);
    chk(lat >= 0, "R8 retry ack", lat, w ? E_LAT_WR : E_LAT_RD);
    finish_op(w, a, d, lat);
    req = 0;
  endtask

  initial begin
    bit ok;
    int lat;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) begin
      model[i]   = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    rst_n = 0; req = 0; we = 0; addr = '0; wdata = '0; mem_ready = 1;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack, "R1 in reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 5'b11100);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack, "R1 after reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 5'b11100);

    // directed: address corners
    xfer(1'b0, 11'd0, 8'h00, 1'b0);
    xfer(1'b1, 11'd0, 8'hA5, 1'b0);
    xfer(1'b1, 11'd2047, 8'h3C, 1'b1);
    xfer(1'b0, 11'd2047, 8'h00, 1'b1);
    xfer(1'b0, 11'd0, 8'h00, 1'b0);

    // R7: request held off while not ready
    req = 0;
    @(negedge clk);
    mem_ready = 0; req = 1; we = 1; addr = 11'd100; wdata = 8'hC3;
    ok = 1;
    repeat (6) begin
      @(negedge clk);
      if (!mem_ce_n || ack) ok = 0;
    end
    chk(ok, "R7 no start", mem_ce_n, 1);
    mem_ready = 1;
    wait_ack(lat);
    chk(lat == E_LAT_WR, "R7 start after ready", lat, E_LAT_WR);
    ref_mem[100] = 8'hC3;
    req = 0;
    xfer(1'b0, 11'd100, 8'h00, 1'b0);

    // R8: aborts in each write phase and in a read
    xfer_abort(1'b1, 11'd7, 8'h81, 3);
    xfer(1'b0, 11'd7, 8'h00, 1'b0);
    xfer_abort(1'b1, 11'd8, 8'h42, 6);
    xfer(1'b0, 11'd8, 8'h00, 1'b0);
    xfer_abort(1'b1, 11'd9, 8'h99, 9);
    xfer(1'b0, 11'd9, 8'h00, 1'b0);
    xfer_abort(1'b0, 11'd8, 8'h00, 5);

    // random traffic
    for (int n = 0; n < 80; n++) begin
      bit w;
      logic [10:0] a;
      w = 1'($urandom_range(0, 1));
      a = ($urandom_range(0, 3) == 0) ? 11'($urandom_range(0, 2047)) : 11'($urandom_range(0, 15));
      xfer(w, a, 8'($urandom), ($urandom_range(0, 7) == 0));
    end

    @(negedge clk);
    chk(viol3 == 0, "R3 oe during write", viol3, 0);
    chk(viol5 == 0, "R5 data held in tail", viol5, 0);
    chk(viol6 == 0, "R6 address moved", viol6, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule